// File: doc/BRIEF.md
# Windowed Batch Warp Halt Controller

This block lets an external debugger stop and restart many warps with a single register write. It keeps one select bit for every warp in the machine. It also shows the halted and active state that each core reports back for its warps. All of this is held in arrays much wider than the 32-bit register port. The debugger therefore first writes a window index, and then reads or writes the one 32-bit slice of each array that the index picks. Warp `w*32+n` appears at bit `n` of window `w`.

A write to the control register with the halt bit set starts a one-cycle fan-out. During that cycle the block raises the halt request line of every selected warp that is not already halted. The resume bit does the same for selected warps that are halted. The control register also reports six summary flags over all configured warps. The flags say whether all or any warps are halted, running (active and not halted) or unavailable (neither active nor halted). An enable bit gates the whole block. While it is 0, the window index and the select array are held at their reset values.

The control logic is a four-state machine: `ST_OFF` (block disabled), `ST_IDLE` (enabled, no command), `ST_HALT_FANOUT` (halt requests are driven) and `ST_RESUME_FANOUT` (resume requests are driven). The transitions are:
- T_ENABLE: `ST_OFF` to `ST_IDLE`, when the enable bit is written to 1.
- T_DISABLE: any state to `ST_OFF`, when the enable is 0.
- T_HALT_CMD: any enabled state to `ST_HALT_FANOUT`, on a halt write.
- T_RESUME_CMD: any enabled state to `ST_RESUME_FANOUT`, on a resume write with no halt bit.
- T_RETURN: a fan-out state back to `ST_IDLE` after one cycle when no new command arrives.

Top module: `warp_halt_ctl`

## Requirements
- R1: Register 1 (WINSEL) holds a window index in bits [9:0] and reads back as written. Register 2 (MASK), register 3 (HALTED) and register 4 (ACTIVE) show window `WINSEL` of their arrays. A window that lies wholly beyond NUM_WARPS reads as 0 in all three.
- R2: A write to register 2 stores the 32 data bits as select bits for warps `WINSEL*32+0..31`. Select bits for warp numbers at or above NUM_WARPS are dropped and read as 0.
- R3: Reading register 3 gives, at bit n, the halted input of warp `WINSEL*32+n`, where 1 means halted.
- R4: Reading register 4 gives, at bit n, the active input of warp `WINSEL*32+n`, where 1 means active.
- R5: A write to register 0 with bit 0 = 1 and bit 1 = 1 sets `warp_halt_req_o` to (select & ~halted) in the cycle after the write, for exactly one cycle. Outside such a cycle the output is 0.
- R6: A write to register 0 with bit 0 = 1, bit 1 = 0 and bit 2 = 1 sets `warp_resume_req_o` to (select & halted) in the next cycle, for one cycle. If bits 1 and 2 are both 1, only the halt is issued.
- R7: Register 0 reads as follows: bit 0 is the enable, bits 1 and 2 read 0, and bits 7:3 and 31:14 are 0. The summary flags are bit 8 all-halted, bit 9 any-halted, bit 10 all-running, bit 11 any-running, bit 12 all-unavailable and bit 13 any-unavailable. Running means active and not halted. Unavailable means neither active nor halted.
- R8: While the enable is 0, WINSEL and MASK read 0 and writes to them have no effect. Halt and resume writes issue no requests.
- R9: The summary flags consider only warps 0..NUM_WARPS-1. For example, all-halted is 1 when every configured warp is halted.
- R10: After reset, the enable, WINSEL and all select bits are 0 and both request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| warp_halted_i | input | NUM_WARPS | Per-warp halted state from the cores |
| warp_active_i | input | NUM_WARPS | Per-warp active state from the cores |
| warp_halt_req_o | output | NUM_WARPS | Per-warp one-cycle halt request |
| warp_resume_req_o | output | NUM_WARPS | Per-warp one-cycle resume request |

## Verification
The assertions take two things for granted. First, `reg_wr` and `reg_addr` are at a defined low value during reset, so the past-write checks never see a command from before reset release. Second, the halted input of a warp does not change in the same cycle that its halt request is issued. Under that second assumption, a request never targets a warp that already shows the requested state. The bench keeps within both assumptions. It holds all register inputs at 0 through reset, and it changes the halted and active vectors only on the falling edge between register accesses, never while a fan-out cycle is being sampled.

// File: rtl/whc_pkg.sv
package whc_pkg;
    localparam int WIN_W  = 32;
    localparam int SEL_W  = 10;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_WINSEL = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd2;
    localparam logic [ADDR_W-1:0] A_HALTED = 3'd3;
    localparam logic [ADDR_W-1:0] A_ACTIVE = 3'd4;

    localparam int B_EN     = 0;
    localparam int B_HALT   = 1;
    localparam int B_RESUME = 2;
    localparam int B_SUM    = 8;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_HALT_FANOUT,
        ST_RESUME_FANOUT
    } whc_state_e;

    typedef struct packed {
        logic any_unavail;
        logic all_unavail;
        logic any_running;
        logic all_running;
        logic any_halted;
        logic all_halted;
    } whc_summary_t;
endpackage

// File: rtl/whc_window_mux.sv
module whc_window_mux #(
    parameter int NUM_WIN = 2,
    parameter int WIN_W   = 32,
    parameter int SEL_W   = 10
) (
    input  logic [NUM_WIN*WIN_W-1:0] arr,
    input  logic [SEL_W-1:0]         sel,
    output logic [WIN_W-1:0]         win
);
    always_comb begin
        win = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (sel == SEL_W'(i)) begin
                win = arr[i*WIN_W +: WIN_W];
            end
        end
    end
endmodule

// File: rtl/whc_summary.sv
module whc_summary
    import whc_pkg::*;
#(
    parameter int NUM_WARPS = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] halted,
    input  logic [NUM_WARPS-1:0] active,
    output whc_summary_t         sum
);
    logic [NUM_WARPS-1:0] running;
    logic [NUM_WARPS-1:0] unavail;

    always_comb begin
        running = active & ~halted;
        unavail = ~active & ~halted;
        sum.all_halted  = &halted;
        sum.any_halted  = |halted;
        sum.all_running = &running;
        sum.any_running = |running;
        sum.all_unavail = &unavail;
        sum.any_unavail = |unavail;
    end

    // R9: an all-flag implies its any-flag over a non-empty warp set
    assert_all_implies_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum.all_halted |-> sum.any_halted) and (sum.all_running |-> sum.any_running)
        and (sum.all_unavail |-> sum.any_unavail));

    // R7: a warp is in exactly one class, so two all-flags never coexist
    assert_classes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sum.all_halted, sum.all_running, sum.all_unavail}) <= 1);
endmodule

// File: rtl/whc_fsm.sv
module whc_fsm
    import whc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_d,
    input  logic       halt_cmd,
    input  logic       resume_cmd,
    output whc_state_e state_q,
    output logic       fan_halt,
    output logic       fan_resume
);
    whc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_d)              state_d = ST_IDLE;           // T_ENABLE
            end
            ST_IDLE, ST_HALT_FANOUT, ST_RESUME_FANOUT: begin
                if (!en_d)             state_d = ST_OFF;            // T_DISABLE
                else if (halt_cmd)     state_d = ST_HALT_FANOUT;    // T_HALT_CMD
                else if (resume_cmd)   state_d = ST_RESUME_FANOUT;  // T_RESUME_CMD
                else                   state_d = ST_IDLE;           // T_RETURN
            end
            default:                   state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        fan_halt   = 1'b0;
        fan_resume = 1'b0;
        unique case (state_q)
            ST_HALT_FANOUT:   fan_halt   = 1'b1;
            ST_RESUME_FANOUT: fan_resume = 1'b1;
            default: ;
        endcase
    end

    // R5: halt fan-out only right after an enabled halt command
    assert_halt_after_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT_FANOUT) |-> $past(halt_cmd && en_d));

    // R6: resume fan-out only after a resume command that carried no halt
    assert_resume_after_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESUME_FANOUT) |-> $past(resume_cmd && !halt_cmd && en_d));

    // R8: a disable always leads to the off state
    assert_disable_to_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_d |=> (state_q == ST_OFF));
endmodule

// File: rtl/warp_halt_ctl.sv
module warp_halt_ctl
    import whc_pkg::*;
#(
    parameter int NUM_WARPS = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WIN_W-1:0]     reg_wdata,
    output logic [WIN_W-1:0]     reg_rdata,
    input  logic [NUM_WARPS-1:0] warp_halted_i,
    input  logic [NUM_WARPS-1:0] warp_active_i,
    output logic [NUM_WARPS-1:0] warp_halt_req_o,
    output logic [NUM_WARPS-1:0] warp_resume_req_o
);
    localparam int NUM_WIN = (NUM_WARPS + WIN_W - 1) / WIN_W;
    localparam int PAD_W   = NUM_WIN * WIN_W;
    localparam logic [PAD_W-1:0] VALID = {PAD_W{1'b1}} >> (PAD_W - NUM_WARPS);

    logic                 en_q, en_d;
    logic [SEL_W-1:0]     winsel_q;
    logic [PAD_W-1:0]     mask_q;
    logic [PAD_W-1:0]     halted_pad, active_pad;
    logic [WIN_W-1:0]     mask_win, halted_win, active_win;
    logic                 ctrl_wr, halt_cmd, resume_cmd;
    logic                 fan_halt, fan_resume;
    whc_state_e           state_q;
    whc_summary_t         sum;

    always_comb begin
        ctrl_wr    = reg_wr && (reg_addr == A_CTRL);
        en_d       = ctrl_wr ? reg_wdata[B_EN] : en_q;
        halt_cmd   = ctrl_wr && reg_wdata[B_HALT];
        resume_cmd = ctrl_wr && reg_wdata[B_RESUME];
        halted_pad = '0;
        active_pad = '0;
        halted_pad[NUM_WARPS-1:0] = warp_halted_i;
        active_pad[NUM_WARPS-1:0] = warp_active_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            winsel_q <= '0;
            mask_q   <= '0;
        end else begin
            en_q <= en_d;
            if (!en_q) begin
                winsel_q <= '0;
                mask_q   <= '0;
            end else if (reg_wr && reg_addr == A_WINSEL) begin
                winsel_q <= reg_wdata[SEL_W-1:0];
            end else if (reg_wr && reg_addr == A_MASK) begin
                for (int w = 0; w < NUM_WIN; w++) begin
                    if (winsel_q == SEL_W'(w)) begin
                        mask_q[w*WIN_W +: WIN_W] <= reg_wdata & VALID[w*WIN_W +: WIN_W];
                    end
                end
            end
        end
    end

    whc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_d       (en_d),
        .halt_cmd   (halt_cmd),
        .resume_cmd (resume_cmd),
        .state_q    (state_q),
        .fan_halt   (fan_halt),
        .fan_resume (fan_resume)
    );

    whc_window_mux #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .SEL_W(SEL_W)) u_mask_mux (
        .arr (mask_q), .sel (winsel_q), .win (mask_win)
    );
    whc_window_mux #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .SEL_W(SEL_W)) u_halt_mux (
        .arr (halted_pad), .sel (winsel_q), .win (halted_win)
    );
    whc_window_mux #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .SEL_W(SEL_W)) u_act_mux (
        .arr (active_pad), .sel (winsel_q), .win (active_win)
    );

    whc_summary #(.NUM_WARPS(NUM_WARPS)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .halted (warp_halted_i),
        .active (warp_active_i),
        .sum    (sum)
    );

    always_comb begin
        warp_halt_req_o   = fan_halt   ? (mask_q[NUM_WARPS-1:0] & ~warp_halted_i) : '0;
        warp_resume_req_o = fan_resume ? (mask_q[NUM_WARPS-1:0] &  warp_halted_i) : '0;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_EN]                = en_q;
                reg_rdata[B_SUM +: $bits(sum)] = sum;
            end
            A_WINSEL: reg_rdata[SEL_W-1:0] = winsel_q;
            A_MASK:   reg_rdata = mask_win;
            A_HALTED: reg_rdata = halted_win;
            A_ACTIVE: reg_rdata = active_win;
            default:  reg_rdata = '0;
        endcase
    end

    // R5: halt requests reach only selected warps
    assert_halt_only_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_halt_req_o & ~mask_q[NUM_WARPS-1:0]) == '0);

    // R6: halt and resume are never driven in the same cycle
    assert_no_dual_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|warp_halt_req_o && |warp_resume_req_o));

    // R5: a halt request is preceded by a halt write one cycle before
    assert_halt_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        |warp_halt_req_o |-> $past(reg_wr && reg_addr == A_CTRL && reg_wdata[B_HALT]));

    // R8: a disabled block keeps its select array clear
    assert_disabled_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_q) |-> (mask_q == '0));

    // R2: selection bits above the warp count never become set
    assert_pad_bits_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~VALID) == '0);
endmodule

// File: tb/warp_halt_ctl_tb.sv
module warp_halt_ctl_tb;
    localparam int NW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NW-1:0] halted = '0;
    logic [NW-1:0] active = '0;
    logic [NW-1:0] hreq, rreq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    warp_halt_ctl #(.NUM_WARPS(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .warp_halted_i(halted), .warp_active_i(active),
        .warp_halt_req_o(hreq), .warp_resume_req_o(rreq)
    );

    // Vector table: write flag, address, data, expected read value, requirement
    localparam int NV = 17;
    localparam bit          V_WR  [NV] = '{1,1,0,0,1,0,1,0,1,0,1,0,0,0,1,0,0};
    localparam logic [2:0]  V_A   [NV] = '{0,1,3,4,2,2,1,3,2,2,1,2,3,4,1,2,1};
    localparam logic [31:0] V_D   [NV] = '{32'h1, 32'h0, 32'h0, 32'h0, 32'hA5A5_1234, 32'h0,
                                           32'h1, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h2, 32'h0,
                                           32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam logic [31:0] V_E   [NV] = '{32'h0, 32'h0, 32'h0000_00FF, 32'hFFFF_0000, 32'h0,
                                           32'hA5A5_1234, 32'h0, 32'h0000_00F0, 32'h0,
                                           32'h0000_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                           32'hA5A5_1234, 32'h0};
    // Requirement per entry: R3 R4 R2 R3 R2 (pad) R1 R1 R1 R2 R1
    localparam int          V_REQ [NV] = '{0,0,3,4,0,2,0,3,0,2,0,1,1,1,0,2,1};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        logic [31:0] r;
        halted = {16'h00F0, 32'h0000_00FF};
        active = {16'hFF00, 32'hFFFF_0000};
        repeat (3) @(negedge clk);
        // R10: reset state
        rd(3'd0, r); check("R10 ctrl", 64'(r[0]), 64'h0);
        rd(3'd1, r); check("R10 winsel", 64'(r), 64'h0);
        check("R10 requests", 64'({hreq, rreq}), 64'h0);
        rst_n = 1'b1;
        rd(3'd2, r); check("R10 mask", 64'(r), 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (V_WR[i]) wr(V_A[i], V_D[i]);
            else begin
                rd(V_A[i], r);
                checks++;
                if (r !== V_E[i]) begin
                    errors++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h", V_REQ[i], i, r, V_E[i]);
                end
            end
        end

        // R7: summary flags and readback of the command bits
        rd(3'd0, r); check("R7 ctrl summaries", 64'(r), 64'h2A01);

        // R5: halt fan-out = select & ~halted, one cycle
        wr(3'd0, 32'h3);
        check("R5 halt fanout", 64'(hreq), 64'hFF0F_A5A5_1200);
        check("R5 no resume", 64'(rreq), 64'h0);
        @(negedge clk);
        check("R5 one cycle", 64'(hreq), 64'h0);
        rd(3'd0, r); check("R7 cmd bits read 0", 64'(r), 64'h2A01);

        // R6: resume fan-out = select & halted
        wr(3'd0, 32'h5);
        check("R6 resume fanout", 64'(rreq), 64'h00F0_0000_0034);
        check("R6 no halt", 64'(hreq), 64'h0);
        @(negedge clk);
        check("R6 one cycle", 64'(rreq), 64'h0);

        // R6: halt wins when both are written
        wr(3'd0, 32'h7);
        check("R6 priority halt", 64'(hreq), 64'hFF0F_A5A5_1200);
        check("R6 priority resume", 64'(rreq), 64'h0);

        // R9: summaries cover only configured warps
        halted = '1;
        rd(3'd0, r); check("R9 all halted", 64'(r), 64'h0301);
        halted = '0; active = '1;
        rd(3'd0, r); check("R9 all running", 64'(r), 64'h0C01);
        active = '0;
        rd(3'd0, r); check("R9 all unavailable", 64'(r), 64'h3001);

        // R8: disable clears and ignores
        halted = {16'h00F0, 32'h0000_00FF};
        wr(3'd0, 32'h0);
        rd(3'd2, r); check("R8 mask cleared", 64'(r), 64'h0);
        wr(3'd1, 32'h1);
        rd(3'd1, r); check("R8 winsel ignored", 64'(r), 64'h0);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, r); check("R8 mask ignored", 64'(r), 64'h0);
        wr(3'd0, 32'h2);
        check("R8 no halt when disabled", 64'(hreq), 64'h0);
        rd(3'd0, r); check("R8 stays disabled", 64'(r[0]), 64'h0);
        wr(3'd0, 32'h1);
        rd(3'd2, r); check("R8 mask after reenable", 64'(r), 64'h0);
        wr(3'd0, 32'h3);
        check("R8 empty select no halt", 64'(hreq), 64'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule